// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a compact 8-bit processor built around an accumulator. It has a 16-bit address space and one byte-wide memory port. Every bus cycle performs at most one memory access. The sequencer spends exactly one clock per access, so an instruction's length in clocks equals the number of bytes it reads or writes. The core runs a reduced instruction set that covers six addressing styles:

- implied (set carry)
- register (the accumulator is the hidden second operand)
- immediate (the operand byte follows the opcode)
- direct (a 16-bit address follows the opcode, low byte first)
- register-indirect through the B:C and H:L pairs
- stack-based subroutine call and return

Memory is expected to answer a read in the same cycle that the address is presented. The core captures read data on the next rising clock edge. Writes take effect on the rising edge of the cycle in which the write strobe is high. When the core meets an opcode it does not know, it stops and raises a halt flag, and it stays stopped until reset.

Top module: `acc_cpu_core`

## Requirements
- R1: Synchronous active-high reset clears the program counter, the stack pointer, every register and both flags, and clears the halt flag. The first cycle after reset is a read of address 0x0000.
- R2: At most one memory access happens per cycle, and read and write strobes are never high together. Until halt, every cycle is an access. The cost of each instruction in cycles is: register ops and set-carry 1; load-immediate, compare-immediate, indirect load and indirect store 2; jumps and return 3; direct load 4; call 5.
- R3: Register field: for opcodes 0x1r to 0x5r, bit 3 is zero and bits 2:0 select the register: B=0, C=1, D=2, E=3, H=4, L=5, accumulator A=7. Opcode 0x5r followed by a byte loads that byte into register r.
- R4: Compare register (0x1r) and compare immediate (0x60, data byte follows) set Z when A equals the operand and set CY when A is unsigned-less than the operand. A is left unchanged.
- R5: Add (0x2r) writes A+r to A, with CY as the carry out and Z set on a zero result. And (0x3r) writes A&r to A, clears CY and sets Z on a zero result. Both take effect in time for the very next instruction.
- R6: Set carry (0x01) sets CY, touches nothing else and uses only its opcode fetch.
- R7: Store indirect (0x4r) writes register r to the byte addressed by H:L. Load indirect (0x62) loads A from the byte addressed by B:C.
- R8: Direct load (0x61, low address byte, high address byte) loads A from that 16-bit address.
- R9: Jump (0x63, low, high) always loads the program counter with the address. Jump-if-zero (0x66) and jump-if-carry (0x67) do the same only when their flag is set; otherwise execution continues after the three bytes.
- R10: Call (0x64, low, high) fetches its three bytes. It then writes the high byte of the return address (the address after the call) to SP-1 and the low byte to SP-2, in that order. SP drops by two and the program counter takes the target.
- R11: Return (0x65) reads the low byte of the program counter from SP and the high byte from SP+1, and SP rises by two.
- R12: Any other opcode (including 0x00, register field 6, or bit 3 set in a register group) raises the halt flag. From then on the core makes no memory access and stays halted until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory address of the current access |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| halted | output | 1 | High once an undefined opcode has stopped the core |

## Verification
A one-byte register operation finishes in the same cycle as the fetch of its own opcode. The accumulator and flag write therefore lands at the same clock edge where the program counter advances and the next opcode is decoded. Chains of back-to-back adds, and a set-carry followed at once by an and that clears the carry, provoke this overlap. Any lost or stale update would then show in a stored result or in a flag probe that follows. The second overlap is the last push of a call: it moves the stack pointer and loads the target in one cycle. Two calls in a row to the same routine are judged on the exact order, addresses and data of the four stack writes.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DW    = 8;
    localparam int AW    = 2 * DW;
    localparam int RSW   = 3;
    localparam int NREG  = 1 << RSW;
    localparam int MEM_W = DW;

    localparam logic [RSW-1:0] ACC_IDX  = 3'd7;
    localparam logic [RSW-1:0] HOLE_IDX = 3'd6;
    localparam logic [AW-1:0]  ADDR_ONE = 16'd1;

    localparam logic [3:0] GRP_CMPR = 4'h1;
    localparam logic [3:0] GRP_ADDR = 4'h2;
    localparam logic [3:0] GRP_ANDR = 4'h3;
    localparam logic [3:0] GRP_STM  = 4'h4;
    localparam logic [3:0] GRP_LDI  = 4'h5;

    localparam logic [7:0] OP_SETC = 8'h01;
    localparam logic [7:0] OP_CMPI = 8'h60;
    localparam logic [7:0] OP_LDAD = 8'h61;
    localparam logic [7:0] OP_LDAX = 8'h62;
    localparam logic [7:0] OP_JMP  = 8'h63;
    localparam logic [7:0] OP_CALL = 8'h64;
    localparam logic [7:0] OP_RET  = 8'h65;
    localparam logic [7:0] OP_JZ   = 8'h66;
    localparam logic [7:0] OP_JC   = 8'h67;

    typedef enum logic [3:0] {
        ST_FETCH, ST_IMM, ST_ALO, ST_AHI, ST_DATA,
        ST_PUSHH, ST_PUSHL, ST_POPL, ST_POPH, ST_HALT
    } seq_state_e;

    typedef enum logic [3:0] {
        K_BAD, K_SETC, K_CMPR, K_ADDR, K_ANDR, K_STM, K_LDI, K_CMPI,
        K_LDAD, K_LDAX, K_JMP, K_CALL, K_RET, K_JZ, K_JC
    } insn_kind_e;

    typedef enum logic [1:0] {ALU_CMP, ALU_ADD, ALU_AND} alu_op_e;

    typedef struct packed {
        insn_kind_e      kind;
        logic [RSW-1:0]  rsel;
    } decoded_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [DW-1:0] opcode,
    output decoded_t      dec
);
    logic reg_form_ok;

    assign reg_form_ok = !opcode[3] && (opcode[2:0] != HOLE_IDX);

    always_comb begin
        dec.kind = K_BAD;
        dec.rsel = opcode[RSW-1:0];
        if (reg_form_ok) begin
            case (opcode[7:4])
                GRP_CMPR: dec.kind = K_CMPR;
                GRP_ADDR: dec.kind = K_ADDR;
                GRP_ANDR: dec.kind = K_ANDR;
                GRP_STM:  dec.kind = K_STM;
                GRP_LDI:  dec.kind = K_LDI;
                default:  dec.kind = K_BAD;
            endcase
        end
        case (opcode)
            OP_SETC: dec.kind = K_SETC;
            OP_CMPI: dec.kind = K_CMPI;
            OP_LDAD: dec.kind = K_LDAD;
            OP_LDAX: dec.kind = K_LDAX;
            OP_JMP:  dec.kind = K_JMP;
            OP_CALL: dec.kind = K_CALL;
            OP_RET:  dec.kind = K_RET;
            OP_JZ:   dec.kind = K_JZ;
            OP_JC:   dec.kind = K_JC;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          cy,
    output logic          z,
    output logic          wr_acc
);
    logic [DW:0] sum;

    assign sum = {1'b0, a} + {1'b0, b};

    always_comb begin
        case (op)
            ALU_ADD: begin
                res = sum[DW-1:0]; cy = sum[DW]; wr_acc = 1'b1;
                z = (sum[DW-1:0] == '0);
            end
            ALU_AND: begin
                res = a & b; cy = 1'b0; wr_acc = 1'b1;
                z = ((a & b) == '0);
            end
            default: begin
                res = a; cy = (a < b); wr_acc = 1'b0;
                z = (a == b);
            end
        endcase
    end
endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
    import acc_cpu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RSW-1:0] wsel,
    input  logic [DW-1:0]  wdata,
    input  logic [RSW-1:0] rsel,
    output logic [DW-1:0]  rdata,
    output logic [DW-1:0]  acc,
    output logic [AW-1:0]  pair_bc,
    output logic [AW-1:0]  pair_hl
);
    logic [NREG-1:0][DW-1:0] bank;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && (wsel == RSW'(i)))
                q <= wdata;
        end
        assign bank[i] = q;
    end

    assign rdata   = bank[rsel];
    assign acc     = bank[ACC_IDX];
    assign pair_bc = {bank[0], bank[1]};
    assign pair_hl = {bank[4], bank[5]};
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [15:0]   mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          halted
);
    seq_state_e     state, state_n;
    logic [AW-1:0]  pc, pc_n, sp, sp_n;
    logic [DW-1:0]  lo_q, lo_n, hi_q, hi_n;
    logic           z_q, z_n, c_q, c_n;
    decoded_t       dec_now, cur_q, act;
    logic           rf_we;
    logic [RSW-1:0] rf_wsel;
    logic [DW-1:0]  rf_wdata, rf_rd, acc_v;
    logic [AW-1:0]  bc_v, hl_v;
    alu_op_e        alu_op;
    logic [DW-1:0]  alu_b, alu_res;
    logic           alu_c, alu_z, alu_wr;

    acc_cpu_decode u_dec (.opcode(mem_rdata), .dec(dec_now));

    assign act   = (state == ST_FETCH) ? dec_now : cur_q;
    assign alu_b = (state == ST_IMM) ? mem_rdata : rf_rd;

    always_comb begin
        case (act.kind)
            K_ADDR:  alu_op = ALU_ADD;
            K_ANDR:  alu_op = ALU_AND;
            default: alu_op = ALU_CMP;
        endcase
    end

    acc_cpu_alu u_alu (
        .op(alu_op), .a(acc_v), .b(alu_b),
        .res(alu_res), .cy(alu_c), .z(alu_z), .wr_acc(alu_wr)
    );

    acc_cpu_regs u_regs (
        .clk(clk), .rst(rst), .we(rf_we), .wsel(rf_wsel), .wdata(rf_wdata),
        .rsel(act.rsel), .rdata(rf_rd), .acc(acc_v), .pair_bc(bc_v), .pair_hl(hl_v)
    );

    always_comb begin
        state_n = state; pc_n = pc; sp_n = sp; lo_n = lo_q; hi_n = hi_q;
        z_n = z_q; c_n = c_q;
        mem_addr = pc; mem_rd = 1'b0; mem_wr = 1'b0; mem_wdata = '0;
        rf_we = 1'b0; rf_wsel = act.rsel; rf_wdata = mem_rdata;
        case (state)
            ST_FETCH: begin
                mem_rd = 1'b1;
                pc_n   = pc + ADDR_ONE;
                case (dec_now.kind)
                    K_SETC: c_n = 1'b1;
                    K_CMPR, K_ADDR, K_ANDR: begin
                        z_n = alu_z; c_n = alu_c;
                        rf_we = alu_wr; rf_wsel = ACC_IDX; rf_wdata = alu_res;
                    end
                    K_STM, K_LDAX:                 state_n = ST_DATA;
                    K_LDI, K_CMPI:                 state_n = ST_IMM;
                    K_LDAD, K_JMP, K_CALL, K_JZ, K_JC: state_n = ST_ALO;
                    K_RET:                         state_n = ST_POPL;
                    default: begin
                        state_n = ST_HALT; pc_n = pc;
                    end
                endcase
            end
            ST_IMM: begin
                mem_rd = 1'b1; pc_n = pc + ADDR_ONE; state_n = ST_FETCH;
                if (act.kind == K_LDI) begin
                    rf_we = 1'b1;
                end else begin
                    z_n = alu_z; c_n = alu_c;
                end
            end
            ST_ALO: begin
                mem_rd = 1'b1; pc_n = pc + ADDR_ONE; lo_n = mem_rdata;
                state_n = ST_AHI;
            end
            ST_AHI: begin
                mem_rd = 1'b1; pc_n = pc + ADDR_ONE; hi_n = mem_rdata;
                state_n = ST_FETCH;
                case (act.kind)
                    K_JMP:  pc_n = {mem_rdata, lo_q};
                    K_JZ:   if (z_q) pc_n = {mem_rdata, lo_q};
                    K_JC:   if (c_q) pc_n = {mem_rdata, lo_q};
                    K_CALL: state_n = ST_PUSHH;
                    default: state_n = ST_DATA;
                endcase
            end
            ST_DATA: begin
                state_n = ST_FETCH;
                case (act.kind)
                    K_STM: begin
                        mem_addr = hl_v; mem_wr = 1'b1; mem_wdata = rf_rd;
                    end
                    K_LDAX: begin
                        mem_addr = bc_v; mem_rd = 1'b1;
                        rf_we = 1'b1; rf_wsel = ACC_IDX;
                    end
                    default: begin
                        mem_addr = {hi_q, lo_q}; mem_rd = 1'b1;
                        rf_we = 1'b1; rf_wsel = ACC_IDX;
                    end
                endcase
            end
            ST_PUSHH: begin
                mem_addr = sp - ADDR_ONE; mem_wr = 1'b1; mem_wdata = pc[AW-1:DW];
                sp_n = sp - ADDR_ONE; state_n = ST_PUSHL;
            end
            ST_PUSHL: begin
                mem_addr = sp - ADDR_ONE; mem_wr = 1'b1; mem_wdata = pc[DW-1:0];
                sp_n = sp - ADDR_ONE; pc_n = {hi_q, lo_q}; state_n = ST_FETCH;
            end
            ST_POPL: begin
                mem_addr = sp; mem_rd = 1'b1; lo_n = mem_rdata;
                sp_n = sp + ADDR_ONE; state_n = ST_POPH;
            end
            ST_POPH: begin
                mem_addr = sp; mem_rd = 1'b1; pc_n = {mem_rdata, lo_q};
                sp_n = sp + ADDR_ONE; state_n = ST_FETCH;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH; pc <= '0; sp <= '0;
            lo_q <= '0; hi_q <= '0; z_q <= 1'b0; c_q <= 1'b0;
            cur_q <= '{kind: K_BAD, rsel: '0};
        end else begin
            state <= state_n; pc <= pc_n; sp <= sp_n;
            lo_q <= lo_n; hi_q <= hi_n; z_q <= z_n; c_q <= c_n;
            if (state == ST_FETCH) cur_q <= dec_now;
        end
    end

    assign halted = (state == ST_HALT);

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R2
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr)); // R12
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R12
    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PUSHH) |=> (mem_wr && (mem_addr == $past(mem_addr) - ADDR_ONE))); // R10
    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && dec_now.kind == K_CMPR) |=> (acc_v == $past(acc_v))); // R4

endmodule

// File: tb/acc_cpu_core_tb.sv
`timescale 1ns/1ps
module acc_cpu_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, halted;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  mem [0:4095];
    int n_chk = 0, n_err = 0;
    int ptr, exp_acc, wcount;
    logic [15:0] wl_addr [0:31];
    logic [7:0]  wl_data [0:31];
    logic [15:0] first_addr;
    logic        first_rd, first_wr, first_halt;

    always #4 clk = ~clk;

    acc_cpu_core u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
    );

    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) begin
        if (mem_wr === 1'b1) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            if (wcount < 32) begin
                wl_addr[wcount] <= mem_addr;
                wl_data[wcount] <= mem_wdata;
            end
            wcount <= wcount + 1;
        end
    end

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic new_prog();
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        ptr = 0; exp_acc = 0;
    endtask

    task automatic emit(input logic [7:0] b);
        mem[12'(ptr)] = b; ptr++;
    endtask

    task automatic e_op1(input logic [7:0] b);
        emit(b); exp_acc += 1;
    endtask

    task automatic e_ldi(input int r, input logic [7:0] v);
        emit(8'h50 | 8'(r)); emit(v); exp_acc += 2;
    endtask

    task automatic e_store(input int r, input logic [15:0] a);
        e_ldi(4, a[15:8]); e_ldi(5, a[7:0]); emit(8'h40 | 8'(r)); exp_acc += 2;
    endtask

    // conditional jump probe: A becomes 1 when taken, 0 when not
    task automatic e_probe(input logic [7:0] op, input bit taken);
        int p;
        p = ptr;
        emit(op); emit(8'(p + 8)); emit(8'((p + 8) >> 8));
        emit(8'h57); emit(8'h00);
        emit(8'h63); emit(8'(p + 10)); emit(8'((p + 10) >> 8));
        emit(8'h57); emit(8'h01);
        exp_acc += taken ? 5 : 8;
    endtask

    task automatic run_prog(input string tag);
        int cyc, acc;
        rst = 1'b1; wcount = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        first_addr = mem_addr; first_rd = mem_rd; first_wr = mem_wr; first_halt = halted;
        cyc = 0; acc = 0;
        while (!halted && cyc < 5000) begin
            if (mem_rd || mem_wr) acc++;
            cyc++;
            @(negedge clk);
        end
        chk_eq({tag, " R2 access count"}, acc, exp_acc);
        chk_eq({tag, " R2 cycle count"}, cyc, exp_acc);
    endtask

    task automatic t_halt();
        bit quiet;
        new_prog(); mem[12'h500] = 8'hEE;
        e_ldi(7, 8'h12); e_op1(8'h46);
        e_store(7, 16'h0500); exp_acc -= 6;
        run_prog("halt field6");
        chk_eq("R12 halt flag", halted, 1);
        quiet = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (mem_rd || mem_wr || !halted) quiet = 1'b0;
            @(negedge clk);
        end
        chk_eq("R12 quiet after halt", quiet, 1);
        chk_eq("R12 no execution past bad opcode", mem[12'h500], 8'hEE);
        new_prog(); e_op1(8'h18);
        run_prog("halt bit3");
        chk_eq("R12 bit3 opcode halts", halted, 1);
    endtask

    task automatic t_reset();
        new_prog();
        for (int i = 0; i < 7; i++) mem[12'h100 + 12'(i)] = 8'hEE;
        e_store(0, 16'h0100); e_store(1, 16'h0101); e_store(2, 16'h0102);
        e_store(3, 16'h0103); e_store(7, 16'h0104);
        e_probe(8'h66, 0); e_store(7, 16'h0105);
        e_probe(8'h67, 0); e_store(7, 16'h0106);
        e_op1(8'h00);
        run_prog("reset");
        chk_eq("R1 first address", first_addr, 16'h0000);
        chk_eq("R1 first access is read", {first_rd, first_wr}, 2'b10);
        chk_eq("R1 halt cleared by reset", first_halt, 0);
        for (int i = 0; i < 5; i++)
            chk_eq("R1 register cleared", mem[12'h100 + 12'(i)], 8'h00);
        chk_eq("R1 Z cleared", mem[12'h105], 8'h00);
        chk_eq("R1 CY cleared", mem[12'h106], 8'h00);
    endtask

    task automatic t_cmp(input logic [7:0] a, input logic [7:0] b, input bit imm);
        new_prog();
        e_ldi(7, a);
        if (imm) begin emit(8'h60); emit(b); exp_acc += 2; end
        else begin e_ldi(0, b); e_op1(8'h10); end
        e_store(7, 16'h0200);
        e_probe(8'h66, a == b); e_store(7, 16'h0201);
        e_probe(8'h67, a < b);  e_store(7, 16'h0202);
        e_op1(8'h00);
        run_prog(imm ? "R4 compare imm" : "R3 R4 compare reg");
        chk_eq("R4 A unchanged by compare", mem[12'h200], a);
        chk_eq("R4 R9 Z after compare", mem[12'h201], 8'(a == b));
        chk_eq("R4 R9 CY after compare", mem[12'h202], 8'(a < b));
    endtask

    task automatic t_alu(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                         input bit pre_c);
        logic [8:0] s;
        logic [7:0] r;
        logic       c;
        if (op == 8'h20) begin s = {1'b0, a} + {1'b0, b}; r = s[7:0]; c = s[8]; end
        else begin r = a & b; c = 1'b0; end
        new_prog();
        e_ldi(7, a); e_ldi(0, b);
        if (pre_c) e_op1(8'h01);
        e_op1(op);
        e_store(7, 16'h0210);
        e_probe(8'h66, r == 0); e_store(7, 16'h0211);
        e_probe(8'h67, c);      e_store(7, 16'h0212);
        e_op1(8'h00);
        run_prog("R5 alu");
        chk_eq("R5 alu result", mem[12'h210], r);
        chk_eq("R5 alu Z", mem[12'h211], 8'(r == 0));
        chk_eq("R5 alu CY", mem[12'h212], 8'(c));
    endtask

    task automatic t_back2back();
        new_prog();
        e_ldi(7, 8'h01); e_ldi(0, 8'h01);
        e_op1(8'h20); e_op1(8'h20); e_op1(8'h27);
        e_store(7, 16'h0218); e_op1(8'h00);
        run_prog("R5 back to back");
        chk_eq("R5 chained adds see each result", mem[12'h218], 8'h06);
    endtask

    task automatic t_setc();
        new_prog();
        e_op1(8'h01);
        e_probe(8'h67, 1); e_store(7, 16'h0220);
        e_op1(8'h00);
        run_prog("R6 set carry");
        chk_eq("R6 CY set", mem[12'h220], 8'h01);
    endtask

    task automatic t_indirect();
        new_prog(); mem[12'h123] = 8'h9C;
        e_ldi(0, 8'h01); e_ldi(1, 8'h23); e_op1(8'h62); exp_acc += 1;
        e_ldi(3, 8'h5A); e_ldi(4, 8'h03); e_ldi(5, 8'h45);
        e_op1(8'h43); exp_acc += 1;
        e_store(7, 16'h0230); e_op1(8'h00);
        run_prog("R7 indirect");
        chk_eq("R7 store via H:L address", wl_addr[0], 16'h0345);
        chk_eq("R7 store via H:L data", mem[12'h345], 8'h5A);
        chk_eq("R7 load via B:C", mem[12'h230], 8'h9C);
    endtask

    task automatic t_direct();
        new_prog(); mem[12'h456] = 8'h3D;
        emit(8'h61); emit(8'h56); emit(8'h04); exp_acc += 4;
        e_store(7, 16'h0240); e_op1(8'h00);
        run_prog("R8 direct");
        chk_eq("R8 direct load", mem[12'h240], 8'h3D);
    endtask

    task automatic t_jump();
        new_prog();
        emit(8'h63); emit(8'h04); emit(8'h00); exp_acc += 3;
        emit(8'h00);
        e_ldi(7, 8'hA5); e_store(7, 16'h0250); e_op1(8'h00);
        run_prog("R9 jump");
        chk_eq("R9 jump skips bytes", mem[12'h250], 8'hA5);
    endtask

    task automatic t_call();
        new_prog();
        emit(8'h64); emit(8'h40); emit(8'h00);
        emit(8'h64); emit(8'h40); emit(8'h00);
        exp_acc += 22;
        e_store(7, 16'h0300); e_op1(8'h00);
        ptr = 16'h40;
        emit(8'h50); emit(8'h11); emit(8'h20); emit(8'h65);
        run_prog("R10 R11 call");
        chk_eq("R10 first push address", wl_addr[0], 16'hFFFF);
        chk_eq("R10 first push high byte", wl_data[0], 8'h00);
        chk_eq("R10 second push address", wl_addr[1], 16'hFFFE);
        chk_eq("R10 second push low byte", wl_data[1], 8'h03);
        chk_eq("R11 SP restored by return", wl_addr[2], 16'hFFFF);
        chk_eq("R11 second call return low", wl_data[3], 8'h06);
        chk_eq("R11 both returns resumed", mem[12'h300], 8'h22);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_halt();
        t_reset();
        t_cmp(8'h40, 8'h50, 0);
        t_cmp(8'h40, 8'h40, 1);
        t_cmp(8'h41, 8'h40, 1);
        t_cmp(8'h00, 8'hFF, 0);
        t_alu(8'h20, 8'hF0, 8'h20, 0);
        t_alu(8'h20, 8'h80, 8'h80, 0);
        t_alu(8'h30, 8'hF0, 8'h0F, 1);
        t_alu(8'h30, 8'h3C, 8'h0F, 1);
        t_back2back();
        t_setc();
        t_indirect();
        t_direct();
        t_jump();
        t_call();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule